// File: doc/BRIEF.md
# Shared-Line Transmit Pin Driver with Turn-On Delay

This block drives the data value and the tri-state output enable of a serial transmit pin. Several devices share that pin on one time-division multiplexed line, and each device drives it only in its own slots. The block is clocked by a fast internal clock. It watches the bit clock as an ordinary synchronous input and treats each rising bit-clock edge as a transmit edge. At that edge it captures the serial bit presented by an upstream serializer. The serializer also supplies a slot-active flag and a first-bit flag that marks the start of each element. Slot selection and serialization happen upstream.

Outside an element that this device owns, the enable stays low, so the pin floats. When the delay-enable input is set at the first bit of an element, the block keeps the enable low for a fixed number of fast-clock cycles after the transmit edge. This guarantees dead time after the previous owner of the line lets go. Later bits of the same element get no added delay. The enable drops at the falling bit-clock edge of the element's last bit, so the line is free before the next transmit edge, where another device may start.

Top module: `tdm_pin_driver`

## Requirements
- R1: After reset `pinOe` is 0. A transmit edge with `slotActive` low clears `pinOe` in the following fast-clock cycle. Bits that arrive in an active slot with no preceding first-bit flag never raise `pinOe`.
- R2: At a transmit edge with `slotActive`=1, `firstBit`=1 and `delayEn`=0, `pinOe` goes to 1 in the same fast-clock cycle in which `pinData` takes the new bit.
- R3: At a transmit edge with `slotActive`=1, `firstBit`=1 and `delayEn`=1, `pinOe` stays 0 for the first TURN_ON_DLY fast-clock cycles after that edge and then goes to 1. The default delay is 2 cycles.
- R4: Once an element is being driven, transmit edges for its later bits keep `pinOe` at 1 with no gap, whatever `delayEn` is.
- R5: `pinOe` falls in the fast-clock cycle after the falling bit-clock edge that ends the ELEM_BITS-th bit of an element. The default is 8 bits.
- R6: `pinData` changes only at a transmit edge with `slotActive`=1, and it then holds the `txBit` value sampled at that edge.
- R7: `delayEn` is used only at the first bit of an element. Changing it during later bits does not change `pinOe`.
- R8: A first-bit flag inside an element restarts the bit count, so the release comes ELEM_BITS bits after the new first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Serial bit clock, synchronous to clk; a rising edge is the transmit edge |
| slotActive | input | 1 | Current slot belongs to this device and is enabled |
| firstBit | input | 1 | Current bit is the first bit of an element |
| txBit | input | 1 | Serial data bit to transmit |
| delayEn | input | 1 | Add extra turn-on delay for the first bit |
| pinData | output | 1 | Data value for the pin driver |
| pinOe | output | 1 | Output enable for the pin driver (0 means high impedance) |

## Verification
A wrong delay count or a wrong state shows up at `pinOe` within the first few fast cycles after a first-bit transmit edge. The enable then either rises inside the dead-time window or never rises, and the bench's per-cycle reference catches this on that cycle. A bit counter that is off by one moves the release to the wrong falling edge. That is seen half a bit period after the last bit, or not until the next element when the release is missed entirely. A wrong data capture is visible on `pinData` in the cycle right after the transmit edge.

// File: rtl/tdm_pin_driver_pkg.sv
package tdm_pin_driver_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DRIVE
  } drvState_t;

  typedef struct packed {
    logic loadData;
    logic oeSet;
    logic oeClr;
  } drvStrobe_t;

endpackage

// File: rtl/tdm_pin_driver_ctrl.sv
module tdm_pin_driver_ctrl
  import tdm_pin_driver_pkg::*;
#(
  parameter int ELEM_BITS   = 8,
  parameter int TURN_ON_DLY = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       slotActive,
  input  logic       firstBit,
  input  logic       delayEn,
  output drvStrobe_t stb
);

  localparam int CNT_W = (ELEM_BITS > 1) ? $clog2(ELEM_BITS) : 1;
  localparam int DLY_W = $clog2(TURN_ON_DLY + 1);

  logic              bitClkQ;
  logic              riseEv;
  logic              fallEv;
  drvState_t         state, stateNxt;
  logic [DLY_W-1:0]  dlyCnt, dlyNxt;
  logic [CNT_W-1:0]  bitsLeft, leftNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitClkQ <= 1'b0;
    else       bitClkQ <= bitClk;
  end

  assign riseEv = bitClk & ~bitClkQ;
  assign fallEv = ~bitClk & bitClkQ;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    dlyNxt   = dlyCnt;
    leftNxt  = bitsLeft;
    if (riseEv) begin
      stb.loadData = slotActive;
      if (!slotActive) begin
        stb.oeClr = 1'b1;
        stateNxt  = ST_IDLE;
        dlyNxt    = '0;
      end else if (firstBit) begin
        leftNxt = CNT_W'(ELEM_BITS - 1);
        if (delayEn) begin
          stb.oeClr = 1'b1;
          stateNxt  = ST_WAIT;
          dlyNxt    = DLY_W'(TURN_ON_DLY);
        end else begin
          stb.oeSet = 1'b1;
          stateNxt  = ST_DRIVE;
          dlyNxt    = '0;
        end
      end else if (state != ST_IDLE && bitsLeft != '0) begin
        leftNxt = bitsLeft - CNT_W'(1);
      end
    end else begin
      if (state == ST_WAIT) begin
        dlyNxt = dlyCnt - DLY_W'(1);
        if (dlyCnt == DLY_W'(1)) begin
          stb.oeSet = 1'b1;
          stateNxt  = ST_DRIVE;
        end
      end
      if (fallEv && state != ST_IDLE && bitsLeft == '0) begin
        stb.oeSet = 1'b0;
        stb.oeClr = 1'b1;
        stateNxt  = ST_IDLE;
        dlyNxt    = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dlyCnt   <= '0;
      bitsLeft <= '0;
    end else begin
      state    <= stateNxt;
      dlyCnt   <= dlyNxt;
      bitsLeft <= leftNxt;
    end
  end

endmodule

// File: rtl/tdm_pin_driver_dp.sv
module tdm_pin_driver_dp
  import tdm_pin_driver_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  drvStrobe_t stb,
  input  logic       txBit,
  output logic       pinData,
  output logic       pinOe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinData <= 1'b0;
      pinOe   <= 1'b0;
    end else begin
      if (stb.loadData) pinData <= txBit;
      if (stb.oeClr)      pinOe <= 1'b0;
      else if (stb.oeSet) pinOe <= 1'b1;
    end
  end

endmodule

// File: rtl/tdm_pin_driver.sv
module tdm_pin_driver
  import tdm_pin_driver_pkg::*;
#(
  parameter int ELEM_BITS   = 8,
  parameter int TURN_ON_DLY = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitClk,
  input  logic slotActive,
  input  logic firstBit,
  input  logic txBit,
  input  logic delayEn,
  output logic pinData,
  output logic pinOe
);

  drvStrobe_t stb;

  tdm_pin_driver_ctrl #(
    .ELEM_BITS  (ELEM_BITS),
    .TURN_ON_DLY(TURN_ON_DLY)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitClk    (bitClk),
    .slotActive(slotActive),
    .firstBit  (firstBit),
    .delayEn   (delayEn),
    .stb       (stb)
  );

  tdm_pin_driver_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .txBit  (txBit),
    .pinData(pinData),
    .pinOe  (pinOe)
  );

endmodule

// File: rtl/tdm_pin_driver_chk.sv
module tdm_pin_driver_chk (
  input logic clk,
  input logic rstN,
  input logic bitClk,
  input logic slotActive,
  input logic firstBit,
  input logic delayEn,
  input logic pinData,
  input logic pinOe
);

  logic prevClk;
  logic riseC;
  logic fallC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b0;
    else       prevClk <= bitClk;
  end

  assign riseC = bitClk & ~prevClk;
  assign fallC = ~bitClk & prevClk;

  p_hiz_r1: assert property (@(posedge clk) disable iff (!rstN)
    (riseC && !slotActive) |=> !pinOe);

  p_direct_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (riseC && slotActive && firstBit && !delayEn) |=> pinOe);

  // dead-time window for the default two-cycle delay
  p_dead_time_r3: assert property (@(posedge clk) disable iff (!rstN)
    (riseC && slotActive && firstBit && delayEn) |=> !pinOe ##1 !pinOe ##1 pinOe);

  p_later_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    (riseC && slotActive && !firstBit && pinOe) |=> pinOe);

  p_release_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinOe) |-> ($past(fallC) || $past(riseC && !slotActive)
                      || $past(riseC && firstBit && delayEn)));

  p_data_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinData) |-> $past(riseC && slotActive));

endmodule

bind tdm_pin_driver tdm_pin_driver_chk u_chk (.*);

// File: tb/tb_tdm_pin_driver.sv
module tb_tdm_pin_driver;

  localparam int CLK_PERIOD = 10;
  localparam int ELEM       = 8;
  localparam int DLY        = 2;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0;
  logic slotActive = 1'b0;
  logic firstBit = 1'b0;
  logic txBit = 1'b0;
  logic delayEn = 1'b0;
  logic pinData;
  logic pinOe;

  int    nChecks = 0;
  int    nFails  = 0;
  string phase   = "R1";

  // behavioural reference
  int   mPrev = 0;
  int   mWait = 0;
  int   mLeft = 0;
  bit   mOe   = 0;
  bit   mData = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_pin_driver #(.ELEM_BITS(ELEM), .TURN_ON_DLY(DLY)) dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .slotActive(slotActive),
    .firstBit(firstBit), .txBit(txBit), .delayEn(delayEn),
    .pinData(pinData), .pinOe(pinOe)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mPrev = 0; mWait = 0; mLeft = 0; mOe = 0; mData = 0;
    end else begin
      bit active;
      bit rise;
      bit fall;
      active = mOe || (mWait > 0);
      rise = (bitClk == 1'b1) && (mPrev == 0);
      fall = (bitClk == 1'b0) && (mPrev == 1);
      mPrev = int'(bitClk);
      if (rise) begin
        if (!slotActive) begin
          mOe = 0; mWait = 0;
        end else begin
          mData = txBit;
          if (firstBit) begin
            mLeft = ELEM - 1;
            if (delayEn) begin mOe = 0; mWait = DLY; end
            else         begin mOe = 1; mWait = 0;   end
          end else if (active && mLeft > 0) begin
            mLeft = mLeft - 1;
          end
        end
      end else begin
        if (mWait > 0) begin
          mWait = mWait - 1;
          if (mWait == 0) mOe = 1;
        end
        if (fall && active && mLeft == 0) begin
          mOe = 0; mWait = 0;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check(phase, "pinOe", pinOe, mOe);
      check({phase, " R6"}, "pinData", pinData, mData);
    end
  end

  task automatic doBit(input logic slot, input logic first, input logic d, input logic den);
    @(negedge clk);
    bitClk = 1'b1; slotActive = slot; firstBit = first; txBit = d; delayEn = den;
    if (slot && first && den) begin
      @(negedge clk); check("R3", "dead-time cycle 1 pinOe", pinOe, 1'b0);
      @(negedge clk); check("R3", "dead-time cycle 2 pinOe", pinOe, 1'b0);
      @(negedge clk); check("R3", "enable after delay", pinOe, 1'b1);
      repeat (HALF_BIT - 3) @(negedge clk);
    end else begin
      repeat (HALF_BIT - 1) @(negedge clk);
    end
    bitClk = 1'b0;
    repeat (HALF_BIT - 1) @(negedge clk);
  endtask

  task automatic sendElem(input logic den, input logic [ELEM-1:0] val);
    for (int i = 0; i < ELEM; i++) doBit(1'b1, i == 0, val[ELEM-1-i], den);
  endtask

  task automatic idleBits(input int n);
    for (int i = 0; i < n; i++) doBit(1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset pinOe", pinOe, 1'b0);
    rstN = 1'b1;

    phase = "R1";
    idleBits(3);
    check("R1", "idle pinOe", pinOe, 1'b0);

    phase = "R2 R4 R5";
    sendElem(1'b0, 8'hA5);
    @(negedge clk); check("R5", "released after element", pinOe, 1'b0);
    idleBits(1);

    phase = "R3 R4 R5";
    sendElem(1'b1, 8'h3C);
    idleBits(2);

    phase = "R1 orphan";
    for (int i = 0; i < 4; i++) doBit(1'b1, 1'b0, i[0], 1'b0);
    check("R1", "orphan bits pinOe", pinOe, 1'b0);

    phase = "R5 R8 back-to-back";
    sendElem(1'b1, 8'h0F);
    sendElem(1'b1, 8'hF0);
    sendElem(1'b0, 8'h96);
    idleBits(1);

    phase = "R1 cut";
    doBit(1'b1, 1'b1, 1'b1, 1'b0);
    doBit(1'b1, 1'b0, 1'b0, 1'b0);
    doBit(1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk); check("R1", "slot dropped pinOe", pinOe, 1'b0);
    idleBits(1);

    phase = "R8 restart";
    for (int i = 0; i < 3; i++) doBit(1'b1, i == 0, 1'b1, 1'b0);
    for (int i = 0; i < ELEM; i++) doBit(1'b1, i == 0, i[1], 1'b0);
    @(negedge clk); check("R8", "release after restart", pinOe, 1'b0);
    idleBits(1);

    phase = "R7 R4";
    doBit(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 1; i < ELEM; i++) begin
      doBit(1'b1, 1'b0, i[0], i[0]);
      check("R7", "mid-element delayEn change", pinOe, (i == ELEM - 1) ? 1'b0 : 1'b1);
    end
    idleBits(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired got running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule